// File: doc/BRIEF.md
# Programmable Serial Bit-Clock Generator

This block derives a serial bit clock from a faster peripheral clock. An 8-bit divide value N sets the length of each bit-clock period to N+1 input cycles, and a divide value of zero is treated as one. Odd divide values give a symmetric waveform. For even divide values the high phase is one input cycle longer than the low phase; this is intended and is not rounded to an even duty cycle. A polarity input inverts the output.

Next to the clock, the block drives two one-cycle strobes. They go high in the input cycle before the output rises or falls. Serial shifters that run on the same fast clock use them to launch and capture data on the correct bit-clock edge. While the enable is low the output stays low and the phase counter is held at zero, so each enable starts a fresh period.

Top module: `sclk_gen`

## Requirements
- R1: With the enable held high, each output period lasts Neff+1 input cycles, where Neff equals the divide value, or 1 when the divide value is 0.
- R2: For odd divide values, the high and low phases each last (Neff+1)/2 cycles.
- R3: A divide value of 0 behaves like 1: the period is 2 cycles, with 1 cycle high and 1 cycle low.
- R4: For even nonzero divide values with polarity 0, the low phase lasts N/2 cycles and the high phase lasts N/2+1 cycles.
- R5: With polarity 1 the output is inverted, so the high and low durations swap. The rise and fall strobes follow the edges of the inverted output.
- R6: `rise_o` is high for exactly one cycle, in the cycle before `sclk_o` changes from 0 to 1. `fall_o` behaves the same way for a change from 1 to 0. No output edge occurs without its strobe, and the two strobes are never high together.
- R7: A change of the divide value takes effect only at the next period boundary. The period that is running finishes with its old phase lengths.
- R8: While `en_i` is low, `sclk_o` is low from the next clock edge onward, whatever the polarity, and the phase counter is held at zero. With polarity 0, after `en_i` is sampled high, the first rise of `sclk_o` comes after exactly one low-phase length of clock edges.
- R9: During and right after reset, with the enable low, `sclk_o`, `rise_o` and `fall_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; when low the output is held low and the counter is held at zero |
| div_i | input | 8 | Divide value N; the period is N+1 cycles, and 0 is treated as 1 |
| pol_i | input | 1 | Output polarity; 1 inverts the bit clock |
| sclk_o | output | 1 | Registered bit clock |
| rise_o | output | 1 | High in the cycle before `sclk_o` rises |
| fall_o | output | 1 | High in the cycle before `sclk_o` falls |

## Verification
The table-driven pass runs the divider on zero, on small and large odd values, on small and large even values, and on inverted polarity. It measures high time, low time and period, which separates a symmetric split from the deliberate long-high split and exposes an unmapped zero. A monitor compares every output transition with the strobe seen one cycle earlier, so a strobe that is misplaced or missing fails in every pattern. Directed tests change the divide value in the middle of a period, to tell a change applied at the boundary from one applied at once, and disable the clock, to show that the output is held low and that counting restarts from zero.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;
  localparam int unsigned DIV_W = 8;
endpackage

// File: rtl/sclk_cnt.sv
module sclk_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] div_i,
  output logic [W-1:0] cnt_nxt_o,
  output logic [W-1:0] per_nxt_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, per_q, cnt_d, per_d, div_eff;
  logic         wrap;

  always_comb begin
    div_eff = (div_i == '0) ? ONE : div_i;
    wrap    = (cnt_q == per_q);
    cnt_d   = (!en_i || wrap) ? '0 : cnt_q + ONE;
    // period only reloads at a boundary or while idle
    per_d   = (!en_i || wrap) ? div_eff : per_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= ONE;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
    end
  end

  assign cnt_nxt_o = cnt_d;
  assign per_nxt_o = per_d;

  assert_cnt_in_period_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= per_q);
  assert_per_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_q != '0);
  assert_per_at_boundary_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q != per_q) |=> $stable(per_q));
  assert_idle_cnt_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/sclk_phase.sv
module sclk_phase #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         pol_i,
  input  logic [W-1:0] cnt_nxt_i,
  input  logic [W-1:0] per_nxt_i,
  output logic         sclk_o,
  output logic         rise_o,
  output logic         fall_o
);
  logic [W:0] low_len;
  logic       sclk_d, sclk_q;

  always_comb begin
    // low phase = floor((per+1)/2); extra cycle of even split lands in high phase
    low_len = ({1'b0, per_nxt_i} + {{W{1'b0}}, 1'b1}) >> 1;
    sclk_d  = en_i & (({1'b0, cnt_nxt_i} >= low_len) ^ pol_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_d;
  end

  assign sclk_o = sclk_q;
  assign rise_o = sclk_d & ~sclk_q;
  assign fall_o = ~sclk_d & sclk_q;

  assert_rise_leads_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> sclk_o);
  assert_fall_leads_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !sclk_o);
  assert_edge_has_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $past(rise_o));
  assert_strobes_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
  assert_idle_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sclk_o);
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int unsigned DIV_W = sclk_gen_pkg::DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             pol_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_nxt, per_nxt;

  sclk_cnt #(.W(DIV_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .div_i     (div_i),
    .cnt_nxt_o (cnt_nxt),
    .per_nxt_o (per_nxt)
  );

  sclk_phase #(.W(DIV_W)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .pol_i     (pol_i),
    .cnt_nxt_i (cnt_nxt),
    .per_nxt_i (per_nxt),
    .sclk_o    (sclk_o),
    .rise_o    (rise_o),
    .fall_o    (fall_o)
  );

  assert_reset_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!sclk_o && !(rise_o && fall_o)));
endmodule

// File: tb/sclk_gen_tb.sv
module sclk_gen_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [7:0] div_i = 8'd0;
  logic       pol_i = 1'b0;
  logic       sclk_o, rise_o, fall_o;

  int checks = 0;
  int errors = 0;
  int strobe_err = 0;

  always #10 clk_i = ~clk_i;

  sclk_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .div_i(div_i),
    .pol_i(pol_i), .sclk_o(sclk_o), .rise_o(rise_o), .fall_o(fall_o)
  );

  typedef struct packed {
    logic [7:0] dv;
    logic       pl;
    logic [8:0] hi;
    logic [8:0] lo;
  } vec_t;

  // expected high/low from R2..R5
  localparam vec_t VECS [12] = '{
    '{8'd0,   1'b0, 9'd1,   9'd1},
    '{8'd1,   1'b0, 9'd1,   9'd1},
    '{8'd2,   1'b0, 9'd2,   9'd1},
    '{8'd3,   1'b0, 9'd2,   9'd2},
    '{8'd4,   1'b0, 9'd3,   9'd2},
    '{8'd7,   1'b0, 9'd4,   9'd4},
    '{8'd10,  1'b0, 9'd6,   9'd5},
    '{8'd255, 1'b0, 9'd128, 9'd128},
    '{8'd254, 1'b0, 9'd128, 9'd127},
    '{8'd4,   1'b1, 9'd2,   9'd3},
    '{8'd7,   1'b1, 9'd4,   9'd4},
    '{8'd0,   1'b1, 9'd1,   9'd1}
  };

  // strobe monitor: every edge must be announced one cycle earlier (R6)
  logic prev_sclk = 1'b0, prev_rise = 1'b0, prev_fall = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_rise != (sclk_o && !prev_sclk)) strobe_err++;
      if (prev_fall != (!sclk_o && prev_sclk)) strobe_err++;
      if (rise_o && fall_o) strobe_err++;
    end
    prev_sclk = sclk_o;
    prev_rise = rise_o;
    prev_fall = fall_o;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(output int hi, output int lo);
    logic prev;
    logic rose;
    prev = sclk_o;
    do begin
      @(negedge clk_i);
      rose = sclk_o && !prev;
      prev = sclk_o;
    end while (!rose);
    hi = 1;
    @(negedge clk_i);
    while (sclk_o) begin hi++; @(negedge clk_i); end
    lo = 0;
    while (!sclk_o) begin lo++; @(negedge clk_i); end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi, lo, k, se, neff;
    // R9 reset state
    #35;
    check("R9 sclk in reset", int'(sclk_o), 0);
    check("R9 rise in reset", int'(rise_o), 0);
    rst_ni = 1'b1;
    step(); step();
    check("R9 sclk after reset", int'(sclk_o), 0);
    check("R9 strobes after reset", int'(rise_o | fall_o), 0);

    foreach (VECS[i]) begin
      en_i = 1'b0; div_i = VECS[i].dv; pol_i = VECS[i].pl;
      step(); step(); step();
      se = strobe_err;
      en_i = 1'b1;
      measure(hi, lo);
      measure(hi, lo);
      neff = (VECS[i].dv == 0) ? 1 : int'(VECS[i].dv);
      check($sformatf("R2/R3/R4/R5 high div=%0d pol=%0d", VECS[i].dv, VECS[i].pl), hi, int'(VECS[i].hi));
      check($sformatf("R2/R3/R4/R5 low div=%0d pol=%0d", VECS[i].dv, VECS[i].pl), lo, int'(VECS[i].lo));
      check($sformatf("R1 period div=%0d", VECS[i].dv), hi + lo, neff + 1);
      check($sformatf("R6 strobe errors div=%0d pol=%0d", VECS[i].dv, VECS[i].pl), strobe_err - se, 0);
    end

    // R7: divide change mid-period waits for the boundary
    en_i = 1'b0; div_i = 8'd2; pol_i = 1'b0;
    step(); step();
    en_i = 1'b1;
    measure(hi, lo);           // ends on negedge of first high cycle
    step();
    div_i = 8'd7;
    hi = 1;
    @(negedge clk_i);
    while (sclk_o) begin hi++; @(negedge clk_i); end
    lo = 0;
    while (!sclk_o) begin lo++; @(negedge clk_i); end
    check("R7 old high phase kept", hi, 2);
    check("R7 new low phase after boundary", lo, 4);
    measure(hi, lo);
    check("R7 new high phase", hi, 4);

    // R8: disable holds low even with inverted polarity
    pol_i = 1'b1; div_i = 8'd4;
    measure(hi, lo);
    step();
    en_i = 1'b0;
    step();
    k = 0;
    for (int j = 0; j < 8; j++) begin
      if (sclk_o || rise_o) k++;
      step();
    end
    check("R8 idle output low", k, 0);
    // restart from zero: div 4 -> low phase 2 edges
    pol_i = 1'b0;
    step();
    en_i = 1'b1;
    k = 0;
    do begin step(); k++; end while (!sclk_o && k < 20);
    check("R8 first rise after enable", k, 2);
    check("R6 strobe errors overall", strobe_err, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule